// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the piece of an 8-bit CPU core's control path that carries out interrupt entry and interrupt return in hardware. It samples a set of interrupt request lines, the global interrupt enable, an instruction-completion strobe, a multi-cycle busy flag and a sleep flag. When it takes a request, it saves the return address on a byte-wide stack in memory that grows downward. It then clears the global enable and asks the core to load the vector of the winning request into the program counter.

A return strobe starts the reverse sequence. The block reads the two saved bytes back, moves the stack pointer up by two, reloads the program counter and sets the global enable again. After every return, exactly one main-program instruction completes before any pending request can be taken. The status register is left to software. The stack memory sits outside the block and uses a synchronous read with one cycle of latency. The block owns the stack pointer.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken at a clock edge where the block is idle, the global enable is 1, at least one request line is high, no return strobe is present and `insn_done` is 1 with `multi_busy` 0. The program counter load pulse (`pc_load`=1, `pc_load_val`=vector) occurs in the 4th cycle after that edge.
- R2: Entry writes exactly two stack bytes, in cycles 1 and 2 after the taking edge. The first write goes to address SP with data PC[7:0]. The second goes to address SP-1 with data PC[12:8] zero-extended. After the entry the stack pointer is SP-2. No read happens during entry, and write and read are never active together.
- R3: While `multi_busy` is 1, no request is taken, even when `insn_done` is 1.
- R4: While `sleeping` is 1, a request is taken without `insn_done`, and the entry is 4 cycles longer. The writes move to cycles 5 and 6 and the load pulse moves to cycle 8.
- R5: Taking a request clears the global enable (`gie`=0 from cycle 1). No request is taken while `gie` is 0.
- R6: Among simultaneous requests, the lowest index wins. Request i has vector 2 + 2*i.
- R7: A return strobe from idle reads the stack at SP+1 in cycle 1 (high byte) and at SP+2 in cycle 2 (low byte). In cycle 4 it pulses `pc_load` with {high[4:0], low}, sets `gie` to 1 and shows SP+2. No stack write happens during a return.
- R8: After a return, the first completing instruction (`insn_done`=1, `multi_busy`=0) cannot take a pending request. The next one can.
- R9: After reset, `gie`=0, `sp`=1023, and all strobes and `irq_ack` are 0.
- R10: `irq_ack` is a one-hot pulse in cycle 1 after the taking edge that marks the winning request.
- R11: `gie_set` and `gie_clr` set and clear the global enable in the cycle after they are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | An instruction completes this cycle |
| multi_busy | input | 1 | A multi-cycle instruction is still executing |
| sleeping | input | 1 | Core is in sleep mode |
| gie_set | input | 1 | Software sets the global interrupt enable |
| gie_clr | input | 1 | Software clears the global interrupt enable |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | input | N_IRQ | Request lines, index 0 highest priority |
| pc_in | input | PC_W | Return address to save |
| stk_rdata | input | D_W | Stack read data (one cycle after read) |
| irq_ack | output | N_IRQ | One-hot acknowledge of the request taken |
| gie | output | 1 | Global interrupt enable |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | SP_W | Stack address |
| stk_wdata | output | D_W | Stack write data |
| sp | output | SP_W | Stack pointer |
| pc_load | output | 1 | Load program counter |
| pc_load_val | output | PC_W | Value to load |
| seq_busy | output | 1 | Sequencer active, core must stall |

## Verification
The edge that takes a request or a return is counted as cycle 0. After it, the acknowledge and the first push are due in cycle 1, the second push in cycle 2 and the vector load in cycle 4. From sleep, the pushes are due in cycles 5 and 6 and the load in cycle 8. A return reads in cycles 1 and 2 and loads, re-enables and shows SP+2 in cycle 4. The bench changes inputs and samples outputs on falling edges. It walks cycle by cycle from the taking edge and compares every output in every cycle of the window, so an early or a late strobe is reported as well as a wrong value.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_SETTLE,
    ST_VEC,
    ST_POP_HI,
    ST_POP_LO,
    ST_POP_WAIT,
    ST_RET
  } seq_state_e;

  typedef enum logic [1:0] {
    SP_HOLD,
    SP_DEC1,
    SP_INC2
  } sp_op_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_IRQ = 4,
  parameter int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req,
  output logic             any,
  output logic [N_IRQ-1:0] grant,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: a line is granted only when no lower line is high.
  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_grant
      if (g == 0) begin : g_first
        assign grant[g] = req[g];
      end else begin : g_rest
        assign grant[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_sp_unit.sv
module irq_sp_unit
  import irq_seq_pkg::*;
#(
  parameter int SP_W    = 10,
  parameter int SP_INIT = (1 << SP_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  sp_op_e          op,
  output logic [SP_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= SP_W'(SP_INIT);
    end else begin
      case (op)
        SP_DEC1: sp <= sp - SP_W'(1);
        SP_INC2: sp <= sp + SP_W'(2);
        default: sp <= sp;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int PC_W     = 13,
  parameter int D_W      = 8,
  parameter int SP_W     = 10,
  parameter int SP_INIT  = (1 << SP_W) - 1,
  parameter int VEC_BASE = 2,
  parameter int VEC_STEP = 2,
  parameter int WAKE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_done,
  input  logic             multi_busy,
  input  logic             sleeping,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             reti,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [D_W-1:0]   stk_rdata,
  output logic [N_IRQ-1:0] irq_ack,
  output logic             gie,
  output logic             stk_we,
  output logic             stk_re,
  output logic [SP_W-1:0]  stk_addr,
  output logic [D_W-1:0]   stk_wdata,
  output logic [SP_W-1:0]  sp,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_load_val,
  output logic             seq_busy
);
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int HI_W  = PC_W - D_W;
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  seq_state_e       state, state_n;
  logic [CNT_W-1:0] wake_cnt, wake_cnt_n;
  logic [PC_W-1:0]  pc_lat, pc_lat_n;
  logic [IDX_W-1:0] idx_lat, idx_lat_n;
  logic [HI_W-1:0]  hi_lat, hi_lat_n;
  logic             shadow, shadow_n;
  logic             gie_n;
  logic [N_IRQ-1:0] ack_n;
  logic             we_n, re_n, pcl_n;
  logic [SP_W-1:0]  addr_n;
  logic [D_W-1:0]   wdata_n;
  logic [PC_W-1:0]  pcv_n;
  sp_op_e           sp_op;

  logic             any_req;
  logic [N_IRQ-1:0] grant;
  logic [IDX_W-1:0] win_idx;
  logic             take;
  logic             unused_rdata_hi;

  assign unused_rdata_hi = ^stk_rdata[D_W-1:HI_W];

  irq_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pick (
    .req   (irq_req),
    .any   (any_req),
    .grant (grant),
    .idx   (win_idx)
  );

  irq_sp_unit #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_sp (
    .clk (clk),
    .rst (rst),
    .op  (sp_op),
    .sp  (sp)
  );

  function automatic logic [PC_W-1:0] vec_of(input logic [IDX_W-1:0] i);
    return PC_W'(VEC_BASE) + PC_W'(i) * PC_W'(VEC_STEP);
  endfunction

  function automatic logic [D_W-1:0] hi_byte(input logic [PC_W-1:0] p);
    return D_W'(p[PC_W-1:D_W]);
  endfunction

  assign take = gie && any_req && !shadow && !reti &&
                ((insn_done && !multi_busy) || sleeping);

  always_comb begin
    state_n    = state;
    wake_cnt_n = wake_cnt;
    pc_lat_n   = pc_lat;
    idx_lat_n  = idx_lat;
    hi_lat_n   = hi_lat;
    shadow_n   = shadow;
    gie_n      = gie_set ? 1'b1 : (gie_clr ? 1'b0 : gie);
    ack_n      = '0;
    we_n       = 1'b0;
    re_n       = 1'b0;
    pcl_n      = 1'b0;
    addr_n     = stk_addr;
    wdata_n    = stk_wdata;
    pcv_n      = pc_load_val;
    sp_op      = SP_HOLD;
    case (state)
      ST_IDLE: begin
        if (shadow && insn_done && !multi_busy) shadow_n = 1'b0;
        if (reti) begin
          state_n = ST_POP_HI;
          re_n    = 1'b1;
          addr_n  = sp + SP_W'(1);
        end else if (take) begin
          gie_n     = 1'b0;
          ack_n     = grant;
          pc_lat_n  = pc_in;
          idx_lat_n = win_idx;
          if (sleeping && WAKE_CYC > 0) begin
            state_n    = ST_WAKE;
            wake_cnt_n = '0;
          end else begin
            state_n = ST_PUSH_LO;
            we_n    = 1'b1;
            addr_n  = sp;
            wdata_n = pc_in[D_W-1:0];
          end
        end
      end
      ST_WAKE: begin
        wake_cnt_n = wake_cnt + CNT_W'(1);
        if (wake_cnt == CNT_W'(WAKE_CYC - 1)) begin
          state_n = ST_PUSH_LO;
          we_n    = 1'b1;
          addr_n  = sp;
          wdata_n = pc_lat[D_W-1:0];
        end
      end
      ST_PUSH_LO: begin
        sp_op   = SP_DEC1;
        state_n = ST_PUSH_HI;
        we_n    = 1'b1;
        addr_n  = sp - SP_W'(1);
        wdata_n = hi_byte(pc_lat);
      end
      ST_PUSH_HI: begin
        sp_op   = SP_DEC1;
        state_n = ST_SETTLE;
      end
      ST_SETTLE: begin
        state_n = ST_VEC;
        pcl_n   = 1'b1;
        pcv_n   = vec_of(idx_lat);
      end
      ST_VEC: state_n = ST_IDLE;
      ST_POP_HI: begin
        state_n = ST_POP_LO;
        re_n    = 1'b1;
        addr_n  = sp + SP_W'(2);
      end
      ST_POP_LO: begin
        hi_lat_n = stk_rdata[HI_W-1:0];
        state_n  = ST_POP_WAIT;
      end
      ST_POP_WAIT: begin
        sp_op   = SP_INC2;
        pcl_n   = 1'b1;
        pcv_n   = {hi_lat, stk_rdata};
        gie_n   = 1'b1;
        state_n = ST_RET;
      end
      ST_RET: begin
        state_n  = ST_IDLE;
        shadow_n = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wake_cnt    <= '0;
      pc_lat      <= '0;
      idx_lat     <= '0;
      hi_lat      <= '0;
      shadow      <= 1'b0;
      gie         <= 1'b0;
      irq_ack     <= '0;
      stk_we      <= 1'b0;
      stk_re      <= 1'b0;
      stk_addr    <= '0;
      stk_wdata   <= '0;
      pc_load     <= 1'b0;
      pc_load_val <= '0;
    end else begin
      state       <= state_n;
      wake_cnt    <= wake_cnt_n;
      pc_lat      <= pc_lat_n;
      idx_lat     <= idx_lat_n;
      hi_lat      <= hi_lat_n;
      shadow      <= shadow_n;
      gie         <= gie_n;
      irq_ack     <= ack_n;
      stk_we      <= we_n;
      stk_re      <= re_n;
      stk_addr    <= addr_n;
      stk_wdata   <= wdata_n;
      pc_load     <= pcl_n;
      pc_load_val <= pcv_n;
    end
  end

  assign seq_busy = (state != ST_IDLE);

  // R2
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && stk_re));

  // R2
  push_at_sp_chk: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (stk_addr == sp));

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    stk_we |=> (sp == $past(sp) - SP_W'(1)));

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_ack));

  // R5
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_ack) |-> !gie);

  // R7
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (gie && !$past(gie) && !$past(gie_set)) |-> pc_load);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int N_IRQ = 4;
  localparam int PC_W  = 13;
  localparam int D_W   = 8;
  localparam int SP_W  = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             insn_done = 1'b0, multi_busy = 1'b0, sleeping = 1'b0;
  logic             gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic [PC_W-1:0]  pc_in = '0;
  logic [D_W-1:0]   stk_rdata = '0;
  logic [N_IRQ-1:0] irq_ack;
  logic             gie, stk_we, stk_re, pc_load, seq_busy;
  logic [SP_W-1:0]  stk_addr, sp;
  logic [D_W-1:0]   stk_wdata;
  logic [PC_W-1:0]  pc_load_val;

  logic [D_W-1:0]   stk_mem [0:(1<<SP_W)-1];
  int n_chk = 0, n_bad = 0;
  int exp_sp = (1 << SP_W) - 1;

  always #10 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .insn_done(insn_done), .multi_busy(multi_busy),
    .sleeping(sleeping), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .irq_req(irq_req), .pc_in(pc_in), .stk_rdata(stk_rdata),
    .irq_ack(irq_ack), .gie(gie), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp(sp), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .seq_busy(seq_busy)
  );

  always @(posedge clk) begin
    if (stk_we) stk_mem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= stk_mem[stk_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [N_IRQ-1:0] m);
    for (int i = N_IRQ - 1; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  function automatic int vec_of(input int i);
    return 2 + 2 * i;
  endfunction

  task automatic entry(input logic [N_IRQ-1:0] mask, input logic [PC_W-1:0] pc,
                       input bit slp, input int busy, input bit shadow_pre);
    int w, off;
    irq_req = mask;
    pc_in   = pc;
    w = lowest(mask);
    if (shadow_pre) begin
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
      chk("R8 shadow blocks ack", int'(irq_ack), 0);
      chk("R8 shadow no push", int'(stk_we), 0);
    end
    for (int b = 0; b < busy; b++) begin
      multi_busy = 1'b1;
      insn_done  = 1'b1;
      @(negedge clk);
      chk("R3 busy blocks ack", int'(irq_ack), 0);
    end
    multi_busy = 1'b0;
    if (slp) begin sleeping = 1'b1; insn_done = 1'b0; end
    else insn_done = 1'b1;
    @(negedge clk);
    sleeping  = 1'b0;
    insn_done = 1'b0;
    irq_req   = '0;
    chk("R10 R6 ack", int'(irq_ack), 1 << w);
    chk("R5 gie cleared", int'(gie), 0);
    off = slp ? 4 : 0;
    for (int c = 1; c <= 4 + off; c++) begin
      if (c > 1) @(negedge clk);
      if (c == off + 1) begin
        chk("R2 push lo we", int'(stk_we), 1);
        chk("R2 push lo addr", int'(stk_addr), exp_sp);
        chk("R2 push lo data", int'(stk_wdata), int'(pc[7:0]));
      end else if (c == off + 2) begin
        chk("R2 push hi we", int'(stk_we), 1);
        chk("R2 push hi addr", int'(stk_addr), exp_sp - 1);
        chk("R2 push hi data", int'(stk_wdata), int'(pc[12:8]));
      end else begin
        chk(slp ? "R4 no write" : "R2 no write", int'(stk_we), 0);
      end
      chk("R2 no read in entry", int'(stk_re), 0);
      if (c == off + 4) begin
        chk(slp ? "R4 load" : "R1 load", int'(pc_load), 1);
        chk(slp ? "R4 vector" : "R1 vector", int'(pc_load_val), vec_of(w));
      end else begin
        chk(slp ? "R4 no early load" : "R1 no early load", int'(pc_load), 0);
      end
    end
    exp_sp -= 2;
    chk("R2 sp after entry", int'(sp), exp_sp);
    @(negedge clk);
    chk("R1 idle after entry", int'(seq_busy), 0);
  endtask

  task automatic ret(input logic [PC_W-1:0] pc);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    chk("R7 read hi", int'(stk_re), 1);
    chk("R7 read hi addr", int'(stk_addr), exp_sp + 1);
    chk("R7 no write", int'(stk_we), 0);
    @(negedge clk);
    chk("R7 read lo", int'(stk_re), 1);
    chk("R7 read lo addr", int'(stk_addr), exp_sp + 2);
    @(negedge clk);
    chk("R7 quiet", int'(stk_re) + int'(pc_load) + int'(stk_we), 0);
    @(negedge clk);
    exp_sp += 2;
    chk("R7 load", int'(pc_load), 1);
    chk("R7 pc", int'(pc_load_val), int'(pc));
    chk("R7 gie set", int'(gie), 1);
    chk("R7 sp", int'(sp), exp_sp);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N_IRQ-1:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 gie", int'(gie), 0);
    chk("R9 sp", int'(sp), 1023);
    chk("R9 strobes", int'(stk_we) + int'(stk_re) + int'(pc_load) + int'(irq_ack), 0);

    irq_req = 4'b0001; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk("R5 no take when gie 0", int'(irq_ack), 0);
    @(negedge clk);
    chk("R5 no push when gie 0", int'(stk_we), 0);

    gie_set = 1'b1;
    @(negedge clk);
    gie_set = 1'b0;
    chk("R11 set", int'(gie), 1);

    entry(4'b1100, 13'h1abc, 1'b0, 0, 1'b0);
    ret(13'h1abc);
    entry(4'b1111, 13'h0f01, 1'b1, 2, 1'b1);
    ret(13'h0f01);

    for (int it = 0; it < 40; it++) begin
      logic [PC_W-1:0] p;
      m = N_IRQ'($urandom);
      if (m == '0) m = 4'b1000;
      p = PC_W'($urandom);
      entry(m, p, bit'($urandom % 2), int'($urandom % 3), 1'b1);
      ret(p);
    end

    gie_clr = 1'b1;
    @(negedge clk);
    gie_clr = 1'b0;
    chk("R11 clear", int'(gie), 0);
    irq_req = 4'b0010; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk("R11 cleared blocks", int'(irq_ack), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule